// File: doc/BRIEF.md
# Event Dispatcher with Programmable Start-Address Table

This block is the wake-up front end of an event-driven processor core. The core does not poll and has no idle loop. It rests in a wait state until a hardware source reports something. Five sources can raise a single-cycle request pulse: three countdown timers that reached zero, an I/O unit that received a word, and the same I/O unit after its configuration was changed. Each source's request is first latched in a pending flag. One pending flag per cycle is moved into an 8-entry event queue, and a fixed priority decides which one when several are pending.

While the core waits, the dispatcher takes the oldest queued event. It looks up that event's 16-bit program start address in a small writable table and presents a fetch-start command with a valid/ready handshake. The core then runs the program, which ends with a WAIT. The core reports that WAIT on `prog_done`, and the dispatcher returns to the wait state and takes the next queued event.

Top module: `evt_dispatch`

## Requirements
- R1: After reset `fetch_valid` is low, and it stays low until an event request has arrived.
- R2: Event codes are timer0=0, timer1=1, timer2=2, I/O word received=3, I/O configuration changed=4. Bit i of `evt_req` is the request for code i. A fetch for an event presents its code on `fetch_evt` and, on `fetch_addr`, the table entry of that code. Entry i is written by `tbl_we` with `tbl_idx`=i and `tbl_data`.
- R3: Requests pending at the same time enter the queue lowest code first, one per cycle, so they are dispatched in that order.
- R4: Events that enter the queue in different cycles are dispatched in arrival order, whatever their codes.
- R5: The queue holds 8 events. A request that arrives while the queue is full stays pending and is dispatched later, after the queued events.
- R6: Only one program runs at a time. After a fetch is accepted, no further fetch is offered until `prog_done` pulses. A `prog_done` pulse while no program is running (waiting, or fetch not yet accepted) has no effect.
- R7: Once `fetch_valid` is high, it stays high with `fetch_addr` and `fetch_evt` unchanged until `fetch_ready` is seen high.
- R8: A request pulse in the same cycle that an event leaves the queue is captured and dispatched later.
- R9: The start address is the table contents at the moment the event leaves the queue. A table write made while the event was still queued is therefore used.
- R10: A second pulse from a source whose earlier request is still pending merges with it, and only one event results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req | input | 5 | One-cycle request pulses, bit i = event code i |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 3 | Table entry to write (event code) |
| tbl_data | input | 16 | Start address to store |
| fetch_valid | output | 1 | Fetch-start command valid |
| fetch_addr | output | 16 | Program start address |
| fetch_evt | output | 3 | Code of the dispatched event |
| fetch_ready | input | 1 | Core accepts the fetch-start command |
| prog_done | input | 1 | Core executed WAIT; program finished |

## Verification
The hardest case to reach is a full queue with a request still held pending behind it. To get there, the bench accepts one fetch and then keeps the core busy by withholding `prog_done`. It then pulses sources one at a time, a few cycles apart, until eight events are queued. Next it pulses the I/O-receive source twice while the queue is full. The bench then releases the core program by program and checks that exactly ten fetches appear: the busy one, the eight queued ones and the single merged pending one. A second awkward case is a request that lands on the same edge as a dequeue. The bench aligns it by pulsing the request on the cycle right after `prog_done`.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_EVT = 5;
  localparam int EVT_W   = $clog2(NUM_EVT);

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RUN   = 2'd2
  } disp_st_e;
endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          grant_valid,
  output logic [IW-1:0] grant_idx,
  output logic [N-1:0]  pend_q
);
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  logic [N-1:0] clear_mask;

  assign grant_valid = |pend_q;
  assign grant_idx   = lowest_set(pend_q);

  always_comb begin
    clear_mask = '0;
    if (take && grant_valid) clear_mask[grant_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clear_mask) | req;
  end

  // R3: nothing of a lower code is pending when a grant is given
  assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((pend_q & ((N'(1) << grant_idx) - N'(1))) == '0));

  generate
    for (genvar g = 0; g < N; g++) begin : g_hold
      // R5: a pending request is never lost until it is moved to the queue
      assert_pending_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[g] && !(take && grant_idx == IW'(g))) |=> pend_q[g]);
    end
  endgenerate
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= ptr_next(wr_ptr);
      end
      if (do_pop) rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R5: the producer never pushes into a full queue that is not draining
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |-> !push);

  // R5: occupancy never exceeds the depth
  assert_depth_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/evt_table.sv
module evt_table #(
  parameter int N  = 5,
  parameter int IW = 3,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] entry [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n)                         entry[g] <= '0;
        else if (we && widx == IW'(g))      entry[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = (int'(ridx) < N) ? entry[ridx] : '0;
endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch #(
  parameter int NUM_EVT = evt_pkg::NUM_EVT,
  parameter int EVT_W   = evt_pkg::EVT_W,
  parameter int ADDR_W  = 16,
  parameter int QDEPTH  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic               tbl_we,
  input  logic [EVT_W-1:0]   tbl_idx,
  input  logic [ADDR_W-1:0]  tbl_data,
  output logic               fetch_valid,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [EVT_W-1:0]   fetch_evt,
  input  logic               fetch_ready,
  input  logic               prog_done
);
  import evt_pkg::*;

  disp_st_e           st_q;
  logic               arb_valid, q_push, q_pop, q_empty, q_full;
  logic [EVT_W-1:0]   arb_idx, q_head;
  logic [NUM_EVT-1:0] pend_q;
  logic [ADDR_W-1:0]  tbl_rdata;
  logic               handshake;

  // named internal events for the checks
  assign q_pop     = (st_q == ST_WAIT) && !q_empty;
  assign q_push    = arb_valid && (!q_full || q_pop);
  assign handshake = fetch_valid && fetch_ready;

  evt_arbiter #(.N(NUM_EVT), .IW(EVT_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(evt_req), .take(q_push),
    .grant_valid(arb_valid), .grant_idx(arb_idx), .pend_q(pend_q)
  );

  evt_fifo #(.DEPTH(QDEPTH), .W(EVT_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(arb_idx), .pop(q_pop),
    .dout(q_head), .empty(q_empty), .full(q_full)
  );

  evt_table #(.N(NUM_EVT), .IW(EVT_W), .AW(ADDR_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wdata(tbl_data),
    .ridx(q_head), .rdata(tbl_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_WAIT;
      fetch_addr <= '0;
      fetch_evt  <= '0;
    end else begin
      unique case (st_q)
        ST_WAIT: if (q_pop) begin
          fetch_evt  <= q_head;
          fetch_addr <= tbl_rdata;
          st_q       <= ST_ISSUE;
        end
        ST_ISSUE: if (fetch_ready) st_q <= ST_RUN;
        ST_RUN:   if (prog_done)   st_q <= ST_WAIT;
        default:  st_q <= ST_WAIT;
      endcase
    end
  end

  assign fetch_valid = (st_q == ST_ISSUE);

  // R7: command held steady until accepted
  assert_hold_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr) && $stable(fetch_evt)));

  // R6: an accepted fetch is not followed by another one in the next cycle
  assert_single_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    handshake |=> !fetch_valid);

  // R6: while running, the queue is not drained
  assert_no_pop_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !prog_done) |=> !fetch_valid);

  // R1: a fetch only follows an event that was queued
  assert_fetch_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid) |-> $past(q_pop));
endmodule

// File: tb/test_evt_dispatch.sv
`timescale 1ns/1ps
module test_evt_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt_req = '0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [15:0] tbl_data = '0;
  logic        fetch_valid;
  logic [15:0] fetch_addr;
  logic [2:0]  fetch_evt;
  logic        fetch_ready = 1'b0;
  logic        prog_done = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  evt_dispatch i_evt_dispatch (
    .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_data(tbl_data), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_evt(fetch_evt), .fetch_ready(fetch_ready),
    .prog_done(prog_done)
  );

  function automatic logic [15:0] addr_of(input int code);
    return 16'h4000 + 16'(code * 16'h0110);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk) evt_req = m;
    @(negedge clk) evt_req = '0;
  endtask

  task automatic twr(input int idx, input logic [15:0] v);
    @(negedge clk) begin tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_data = v; end
    @(negedge clk) tbl_we = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk) prog_done = 1'b1;
    @(negedge clk) prog_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait for a fetch, compare it, accept it
  task automatic expect_fetch(input int code, input logic [15:0] addr, input string tag);
    bit seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (fetch_valid) seen = 1;
    end
    check(seen, {tag, " fetch_valid"}, int'(fetch_valid), 1);
    if (seen) begin
      check(fetch_evt == 3'(code), {tag, " fetch_evt"}, int'(fetch_evt), code);
      check(fetch_addr == addr, {tag, " fetch_addr"}, int'(fetch_addr), int'(addr));
      fetch_ready = 1'b1;
      @(negedge clk) fetch_ready = 1'b0;
    end
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fetch_valid) bad = 1;
    end
    check(!bad, tag, int'(bad), 0);
  endtask

  task automatic t_reset();
    idle(2);
    check(fetch_valid == 1'b0, "R1 reset no fetch", int'(fetch_valid), 0);
    rst_n = 1'b1;
    expect_quiet(10, "R1 idle after reset");
    for (int i = 0; i < 5; i++) twr(i, addr_of(i));
  endtask

  task automatic t_lookup();
    for (int i = 0; i < 5; i++) begin
      pulse(5'(1 << i));
      expect_fetch(i, addr_of(i), "R2 lookup");
      done_pulse();
    end
  endtask

  task automatic t_hold();
    bit steady = 1;
    pulse(5'b00100);
    idle(4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!fetch_valid || fetch_evt != 3'd2 || fetch_addr != addr_of(2)) steady = 0;
    end
    check(steady, "R7 held until ready", int'(steady), 1);
    expect_fetch(2, addr_of(2), "R7 accept");
    done_pulse();
  endtask

  task automatic t_priority();
    pulse(5'b11111);
    for (int i = 0; i < 5; i++) begin
      expect_fetch(i, addr_of(i), "R3 priority order");
      done_pulse();
    end
  endtask

  task automatic t_arrival();
    pulse(5'b00100);
    expect_fetch(2, addr_of(2), "R4 busy program");
    pulse(5'b10000);
    pulse(5'b00001);
    idle(3);
    done_pulse();
    expect_fetch(4, addr_of(4), "R4 first arrival");
    done_pulse();
    expect_fetch(0, addr_of(0), "R4 second arrival");
    done_pulse();
  endtask

  task automatic t_done_ignored();
    done_pulse();
    expect_quiet(6, "R6 done while waiting ignored");
    pulse(5'b10100);
    idle(4);
    done_pulse();
    check(fetch_valid && fetch_evt == 3'd2, "R6 done before accept ignored", int'(fetch_evt), 2);
    expect_fetch(2, addr_of(2), "R6 first program");
    expect_quiet(10, "R6 no fetch while running");
    done_pulse();
    expect_fetch(4, addr_of(4), "R6 next program");
    done_pulse();
  endtask

  task automatic t_full();
    pulse(5'b00001);
    expect_fetch(0, addr_of(0), "R5 busy program");
    for (int k = 0; k < 8; k++) begin
      pulse(5'(1 << (k % 5)));
      idle(2);
    end
    pulse(5'b01000);
    idle(1);
    pulse(5'b01000);
    idle(3);
    for (int k = 0; k < 8; k++) begin
      done_pulse();
      expect_fetch(k % 5, addr_of(k % 5), "R5 queued entry");
    end
    done_pulse();
    expect_fetch(3, addr_of(3), "R5 held request not dropped");
    done_pulse();
    expect_quiet(15, "R10 repeated pending pulse merged");
  endtask

  task automatic t_same_cycle();
    pulse(5'b00010);
    expect_fetch(1, addr_of(1), "R8 busy program");
    pulse(5'b01000);
    idle(2);
    @(negedge clk) prog_done = 1'b1;
    @(negedge clk) begin prog_done = 1'b0; evt_req = 5'b00001; end
    @(negedge clk) evt_req = '0;
    expect_fetch(3, addr_of(3), "R8 dequeued entry");
    done_pulse();
    expect_fetch(0, addr_of(0), "R8 captured at dequeue");
    done_pulse();
  endtask

  task automatic t_rewrite();
    pulse(5'b00001);
    expect_fetch(0, addr_of(0), "R9 busy program");
    pulse(5'b10000);
    idle(2);
    twr(4, 16'hBEEF);
    done_pulse();
    expect_fetch(4, 16'hBEEF, "R9 new table value used");
    done_pulse();
    twr(4, addr_of(4));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_lookup();
    t_hold();
    t_priority();
    t_arrival();
    t_done_ignored();
    t_full();
    t_same_cycle();
    t_rewrite();
    idle(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule